// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Code Registers

This block is the digital front end of an eight-channel, 14-bit voltage-output converter, built as synchronous logic. A parallel port carries a 14-bit word and a 3-bit channel number. A single write strobe stores the word in that channel's staging register. The code that drives the channel's output sits in a second register per channel. That second stage changes only on a broadcast load or a broadcast clear, so software can stage new codes on every channel and then update all outputs in the same cycle.

The load and clear controls are active low and may arrive with no relation to the clock. Each one passes through a two-flop synchronizer. While the synchronized load is low, every output register follows its staging register. While the synchronized clear is low, every output is forced to code zero, which is the ground-reference level, and every channel raises its cleared flag. Clear wins over load. Clear leaves the staging registers untouched, so a load after the release restores the programmed codes.

Top module: `dbuf_dac_regs`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, every staging and output register goes to code 0 and every `cleared` flag goes to 1. The synchronizers reset to the inactive (high) level.
- R2: A rising edge with `wr_en` high stores `wr_data` in the staging register of channel `wr_addr`. While load and clear are inactive, no output code and no flag changes.
- R3: When `load_n` is driven low with clear inactive, all eight output codes take their staging values together at the third rising edge after the change, and all `cleared` flags fall at that same edge. After two edges the outputs still hold their old values.
- R4: While the synchronized load is low, the outputs follow the staging registers. A word written at edge k appears on `dac_code` at edge k+1.
- R5: When `clear_n` is driven low, every output code becomes 0 and every `cleared` flag becomes 1 at the third rising edge after the change. This holds whatever `wr_en` and `load_n` are doing.
- R6: Clear does not alter the staging registers. A load that follows the release of clear restores the codes written before the clear.
- R7: Clear has priority over load. With both active, the outputs stay at 0. A load still held when clear is released transfers the staging registers at the third rising edge after `clear_n` rises.
- R8: Channel i occupies bits [14*i+13 : 14*i] of `dac_code` and bit i of `cleared`. The address value i selects channel i.
- R9: A write made while clear is active still updates the addressed staging register. The new word appears on the next load after the release.
- R10: Once clear is released and no load is active, the outputs stay at 0 with `cleared` high until a load occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, active high |
| wr_addr | input | 3 | Channel number of the write |
| wr_data | input | 14 | Code to stage |
| load_n | input | 1 | Broadcast transfer, active low, asynchronous |
| clear_n | input | 1 | Broadcast clear to ground code, active low, asynchronous |
| dac_code | output | 112 | Eight output codes, channel i at bits 14*i+13:14*i |
| cleared | output | 8 | Per-channel flag, high while the output holds the cleared state |

## Verification
A write reaches its staging register at the next rising edge. It reaches the outputs one edge after that only when load is already synchronized low. A change on `load_n` or `clear_n` reaches the outputs at the third rising edge: two synchronizer stages plus the output register. The bench changes inputs just after a falling edge and samples at falling edges. For every control change it checks the outputs after two rising edges, where the old value must still be present, and again after the third, where the new value must be present. Each check compares all 112 code bits and all eight flags against a shadow model that the bench builds from the requirements.

// File: rtl/dbuf_dac_pkg.sv
package dbuf_dac_pkg;
   localparam int unsigned DEF_CHANNELS    = 8;
   localparam int unsigned DEF_CODE_W      = 14;
   localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/dbuf_ctl_sync.sv
module dbuf_ctl_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (rst) begin
               sr <= {STAGES{RST_VAL}};
            end else begin
               sr[0] <= d;
               for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dbuf_dac_channel.sv
module dbuf_dac_channel #(
   parameter int unsigned CODE_W = 14
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_hit,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              ld,
   input  logic              clr,
   output logic [CODE_W-1:0] code,
   output logic              cleared
);
   logic [CODE_W-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= '0;
         code    <= '0;
         cleared <= 1'b1;
      end else begin
         if (wr_hit) stage_q <= wr_data;
         if (clr) begin
            code    <= '0;
            cleared <= 1'b1;
         end else if (ld) begin
            code    <= stage_q;
            cleared <= 1'b0;
         end
      end
   end

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!ld && !clr) |=> ($stable(code) && $stable(cleared)));

   // R5
   clear_forces_ground_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> (code == '0 && cleared));

   // R7
   clear_beats_load_chk: assert property (@(posedge clk) disable iff (rst)
      (clr && ld) |=> (code == '0));

   // R3
   load_drops_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (ld && !clr) |=> !cleared);
endmodule

// File: rtl/dbuf_dac_regs.sv
module dbuf_dac_regs
   import dbuf_dac_pkg::*;
#(
   parameter int unsigned CHANNELS    = DEF_CHANNELS,
   parameter int unsigned CODE_W      = DEF_CODE_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   localparam int unsigned ADDR_W     = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
   localparam int unsigned BUS_W      = CHANNELS * CODE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              load_n,
   input  logic              clear_n,
   output logic [BUS_W-1:0]  dac_code,
   output logic [CHANNELS-1:0] cleared
);
   generate
      if (CHANNELS < 2) begin : g_bad_channels
         $error("dbuf_dac_regs: CHANNELS must be at least 2");
      end
      if (CODE_W < 1) begin : g_bad_width
         $error("dbuf_dac_regs: CODE_W must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("dbuf_dac_regs: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic load_s_n, clear_s_n;

   dbuf_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_load_sync (
      .clk(clk), .rst(rst), .d(load_n), .q(load_s_n));

   dbuf_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clear_sync (
      .clk(clk), .rst(rst), .d(clear_n), .q(clear_s_n));

   logic [CHANNELS-1:0] hit;

   generate
      for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
         assign hit[c] = wr_en && (wr_addr == ADDR_W'(c));
         dbuf_dac_channel #(.CODE_W(CODE_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (hit[c]),
            .wr_data (wr_data),
            .ld      (!load_s_n),
            .clr     (!clear_s_n),
            .code    (dac_code[c*CODE_W +: CODE_W]),
            .cleared (cleared[c]));
      end
   endgenerate

   // R8
   single_target_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit));

   // R3
   uniform_flags_chk: assert property (@(posedge clk) disable iff (rst)
      (cleared == '0) || (cleared == '1));
endmodule

// File: tb/dbuf_dac_regs_test.sv
`timescale 1ns/1ps
module dbuf_dac_regs_test;
   localparam int N = 8;
   localparam int W = 14;

   logic          clk = 1'b0;
   logic          rst, wr_en, load_n, clear_n;
   logic [2:0]    wr_addr;
   logic [W-1:0]  wr_data;
   logic [N*W-1:0] dac_code;
   logic [N-1:0]  cleared;

   int checks = 0;
   int fails  = 0;

   // write vectors: address, code (addresses deliberately out of order)
   localparam logic [2:0]   VA [N] = '{3'd5, 3'd0, 3'd7, 3'd2, 3'd6, 3'd1, 3'd4, 3'd3};
   localparam logic [W-1:0] VD [N] = '{14'h2A5B, 14'h0001, 14'h3FFF, 14'h1234,
                                      14'h0F0F, 14'h3000, 14'h1555, 14'h2AAA};

   logic [W-1:0]   stage [N];
   logic [N*W-1:0] exp_code;
   logic [N-1:0]   exp_flag;

   always #2.5 clk = ~clk;

   dbuf_dac_regs uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .load_n(load_n), .clear_n(clear_n), .dac_code(dac_code), .cleared(cleared));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req);
      checks++;
      if (dac_code !== exp_code || cleared !== exp_flag) begin
         fails++;
         $display("FAIL %s: code=%h flags=%b expected code=%h flags=%b",
                  req, dac_code, cleared, exp_code, exp_flag);
      end
   endtask

   task automatic expect_loaded();
      for (int i = 0; i < N; i++) exp_code[i*W +: W] = stage[i];
      exp_flag = '0;
   endtask

   task automatic expect_ground();
      exp_code = '0;
      exp_flag = '1;
   endtask

   task automatic write(input logic [2:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(1);
      wr_en = 1'b0;
      stage[a] = d;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      load_n = 1'b1; clear_n = 1'b1;
      for (int i = 0; i < N; i++) stage[i] = '0;
      step(3);
      expect_ground();
      check("R1 reset state");
      rst = 1'b0;
      step(1);

      // R2, R8: write all channels, outputs stay untouched
      for (int v = 0; v < N; v++) begin
         write(VA[v], VD[v]);
         check("R2 write leaves outputs unchanged");
      end

      // R3: broadcast load, latency three edges
      load_n = 1'b0;
      step(2);
      check("R3 outputs still old after two edges");
      step(1);
      expect_loaded();
      check("R3 R8 simultaneous update");

      // R4: write during active load appears one edge later
      wr_en = 1'b1; wr_addr = 3'd6; wr_data = 14'h0ACE;
      step(1);
      wr_en = 1'b0; stage[6] = 14'h0ACE;
      check("R4 not yet visible at write edge");
      step(1);
      expect_loaded();
      check("R4 follows staging one edge later");
      load_n = 1'b1;
      step(3);
      write(3'd1, 14'h1111);
      check("R2 write after load release ignored by outputs");

      // R5: clear with load idle
      clear_n = 1'b0;
      step(2);
      check("R5 outputs held before clear reaches them");
      step(1);
      expect_ground();
      check("R5 clear forces ground");

      // R9, R7: write and load during clear
      write(3'd3, 14'h0777);
      check("R9 write during clear keeps outputs at ground");
      load_n = 1'b0;
      step(3);
      check("R7 load during clear has no effect");
      clear_n = 1'b1;
      step(2);
      check("R7 still ground two edges after release");
      step(1);
      expect_loaded();
      check("R7 R9 R6 held load transfers after release");
      load_n = 1'b1;
      step(3);

      // R10, R6: clear then release with no load
      clear_n = 1'b0;
      step(3);
      expect_ground();
      check("R5 second clear");
      clear_n = 1'b1;
      step(6);
      check("R10 ground retained after release without load");
      load_n = 1'b0;
      step(3);
      load_n = 1'b1;
      expect_loaded();
      check("R6 load restores programmed codes");
      step(4);
      check("R6 codes retained after load pulse");

      // R1: reset in the middle of operation
      rst = 1'b1;
      step(1);
      rst = 1'b0;
      for (int i = 0; i < N; i++) stage[i] = '0;
      expect_ground();
      check("R1 reset clears outputs");
      load_n = 1'b0;
      step(3);
      load_n = 1'b1;
      expect_loaded();
      check("R1 staging registers zeroed by reset");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule